// File: doc/BRIEF.md
# Write-Protection and Status Register Controller for a Serial EEPROM

This block holds the eight-bit status register of a serial EEPROM and rules on every write request the command engine hands it. The engine decodes each instruction, then presents a one-cycle strobe carrying an operation code, the target word address and, for a status write, the new register byte. The controller answers one clock later with a single-cycle grant or deny pulse. It also keeps the write-in-progress flag raised from a grant until the engine reports that the internal write has finished.

Two kinds of protection are applied. In software protection, two block-protect bits fence off nothing, the top quarter, the top half or the whole array against memory writes. In hardware protection, the lock bit together with a low level on the active-low write-protect pin freezes the register itself. A new register value is buffered when it is granted, and it only becomes visible once the write completes. A low-supply detect input cancels any pending write and clears the enable latch.

Top module: `eep_protect_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00. Bit 7 is the lock bit, bits 3:2 are the block-protect field, bit 1 is the write-enable latch, bit 0 is write-in-progress, and bits 6:4 always read 0.
- R2: A strobe with op 0 sets the write-enable latch (bit 1). A strobe with op 1 clears it. The status byte shows the change one cycle after the strobe.
- R3: A strobe with op 2 (memory write) produces a grant pulse one cycle later when the enable latch is 1, no write is in progress and the address lies outside the protected region. Otherwise it produces a deny pulse. Grant and deny are never high together.
- R4: For a 12-bit address, field value 00 protects nothing, 01 protects 0xC00 to 0xFFF, 10 protects 0x800 to 0xFFF, and 11 protects every address.
- R5: A grant sets write-in-progress in the same cycle as the grant pulse. A completion pulse while a write is in progress clears both write-in-progress and the enable latch.
- R6: A strobe with op 3 (register write) changes only bits 7, 3 and 2. Until completion the old values of those bits stay visible, and the new values appear in the cycle after the completion pulse.
- R7: When the lock bit is 1 and the write-protect pin is low, an op 3 strobe is denied. With the pin high, the same strobe is granted if the enable latch is set.
- R8: Low-supply detect clears the enable latch and write-in-progress and discards a buffered register value. A strobe present in the same cycle is denied.
- R9: Any write request made while write-in-progress is 1 is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; models power-on |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_op | input | 2 | 0 set enable, 1 clear enable, 2 memory write, 3 register write |
| cmd_addr | input | ADDR_W | Word address of a memory write |
| cmd_data | input | 8 | New status byte for a register write |
| wp_n | input | 1 | Write-protect pin, active low |
| wr_done | input | 1 | Internal write finished, from the command engine |
| lvd | input | 1 | Low-supply detect |
| status_q | output | 8 | Status byte returned by a status read |
| grant | output | 1 | Request accepted, one-cycle pulse |
| deny | output | 1 | Request refused, one-cycle pulse |

## Verification
Every piece of internal state appears in the status byte, so a wrong enable latch, progress flag or protect field shows up on `status_q` one cycle after the command that corrupted it. A wrong region decode or lock decision shows up as a swapped grant/deny pulse one cycle after the strobe. A buffered register value that leaks early is caught by reading the status byte between the grant and the completion. A value that was never committed, or that survives low-supply detect, is caught by reading it back after the completion pulse.

// File: rtl/eep_prot_pkg.sv
package eep_prot_pkg;
  typedef enum logic [1:0] {
    OP_SET_WEL  = 2'd0,
    OP_CLR_WEL  = 2'd1,
    OP_MEM_WR   = 2'd2,
    OP_STAT_WR  = 2'd3
  } eep_op_e;

  // Region test on the two most significant address bits.
  function automatic logic in_locked_region(input logic [1:0] bp, input logic [1:0] top2);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return (top2 == 2'b11);
      2'b10:   return top2[1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] pack_status(input logic srwd, input logic [1:0] bp,
                                             input logic wel, input logic wip);
    return {srwd, 3'b000, bp, wel, wip};
  endfunction
endpackage

// File: rtl/eep_write_guard.sv
module eep_write_guard
  import eep_prot_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              cmd_valid,
  input  eep_op_e           op,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wel,
  input  logic              wip,
  input  logic              srwd,
  input  logic [1:0]        bp,
  input  logic              wp_n,
  input  logic              lvd,
  output logic              grant_d,
  output logic              deny_d,
  output logic              hw_locked,
  output logic              addr_locked
);
  localparam int TOP_LSB = ADDR_W - 2;

  logic is_req;
  logic ok;

  assign hw_locked   = srwd && !wp_n;
  assign addr_locked = in_locked_region(bp, addr[ADDR_W-1:TOP_LSB]);
  assign is_req      = cmd_valid && (op == OP_MEM_WR || op == OP_STAT_WR);

  always_comb begin
    ok = wel && !wip && !lvd;
    if (op == OP_MEM_WR)  ok = ok && !addr_locked;
    if (op == OP_STAT_WR) ok = ok && !hw_locked;
  end

  assign grant_d = is_req && ok;
  assign deny_d  = is_req && !ok;
endmodule

// File: rtl/eep_status_core.sv
module eep_status_core (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_wel,
  input  logic       clr_wel,
  input  logic       start_mem,
  input  logic       start_stat,
  input  logic [2:0] stat_bits,
  input  logic       wr_done,
  input  logic       lvd,
  output logic       srwd,
  output logic [1:0] bp,
  output logic       wel,
  output logic       wip
);
  logic       pend_stat;
  logic [2:0] pend_bits;
  logic       finish;

  assign finish = wip && wr_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srwd      <= 1'b0;
      bp        <= 2'b00;
      wel       <= 1'b0;
      wip       <= 1'b0;
      pend_stat <= 1'b0;
      pend_bits <= 3'b000;
    end else if (lvd) begin
      wel       <= 1'b0;
      wip       <= 1'b0;
      pend_stat <= 1'b0;
    end else if (finish) begin
      wip       <= 1'b0;
      wel       <= 1'b0;
      pend_stat <= 1'b0;
      if (pend_stat) begin
        srwd <= pend_bits[2];
        bp   <= pend_bits[1:0];
      end
    end else begin
      if (start_mem || start_stat) wip <= 1'b1;
      if (start_stat) begin
        pend_stat <= 1'b1;
        pend_bits <= stat_bits;
      end
      if (set_wel)      wel <= 1'b1;
      else if (clr_wel) wel <= 1'b0;
    end
  end

  AST_LVD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    lvd |=> (!wel && !wip)); // R8
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !lvd) |=> (!wel && !wip)); // R5
  AST_NV_STABLE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && !wr_done) |=> ($stable(srwd) && $stable(bp))); // R6
  AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    ((start_mem || start_stat) && !lvd) |=> wip); // R5
endmodule

// File: rtl/eep_protect_ctrl.sv
module eep_protect_ctrl
  import eep_prot_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              wp_n,
  input  logic              wr_done,
  input  logic              lvd,
  output logic [7:0]        status_q,
  output logic              grant,
  output logic              deny
);
  eep_op_e    op;
  logic       srwd, wel, wip;
  logic [1:0] bp;
  logic       grant_d, deny_d, hw_locked, addr_locked;
  logic       set_wel, clr_wel, start_mem, start_stat;

  assign op         = eep_op_e'(cmd_op);
  assign set_wel    = cmd_valid && op == OP_SET_WEL;
  assign clr_wel    = cmd_valid && op == OP_CLR_WEL;
  assign start_mem  = grant_d && op == OP_MEM_WR;
  assign start_stat = grant_d && op == OP_STAT_WR;

  eep_write_guard #(.ADDR_W(ADDR_W)) guard_i (
    .cmd_valid(cmd_valid), .op(op), .addr(cmd_addr), .wel(wel), .wip(wip),
    .srwd(srwd), .bp(bp), .wp_n(wp_n), .lvd(lvd),
    .grant_d(grant_d), .deny_d(deny_d), .hw_locked(hw_locked), .addr_locked(addr_locked)
  );

  eep_status_core core_i (
    .clk(clk), .rst_n(rst_n), .set_wel(set_wel), .clr_wel(clr_wel),
    .start_mem(start_mem), .start_stat(start_stat),
    .stat_bits({cmd_data[7], cmd_data[3:2]}), .wr_done(wr_done), .lvd(lvd),
    .srwd(srwd), .bp(bp), .wel(wel), .wip(wip)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant <= 1'b0;
      deny  <= 1'b0;
    end else begin
      grant <= grant_d;
      deny  <= deny_d;
    end
  end

  assign status_q = pack_status(srwd, bp, wel, wip);

  AST_GRANT_DENY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant, deny})); // R3
  AST_GRANT_RAISES_WIP: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> status_q[0]); // R5
  AST_HW_LOCK_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_STAT_WR && hw_locked) |=> (deny && !grant)); // R7
  AST_NO_GRANT_NO_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !wel) |=> !grant); // R3
  AST_BUSY_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op[1] && wip) |=> !grant); // R9
  AST_REGION_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_MEM_WR && addr_locked) |=> !grant); // R4
endmodule

// File: tb/eep_protect_ctrl_tb.sv
module eep_protect_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0]    cmd_data = 8'h00;
  logic          wp_n = 1'b1;
  logic          wr_done = 1'b0;
  logic          lvd = 1'b0;
  logic [7:0]    status_q;
  logic          grant, deny;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  eep_protect_ctrl #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wp_n(wp_n), .wr_done(wr_done),
    .lvd(lvd), .status_q(status_q), .grant(grant), .deny(deny)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  // Drive one strobe at a falling edge, check the response at the next one.
  task automatic cmd(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                     input string req, input logic exp_g, input logic exp_d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (op[1]) chk(req, {6'd0, grant, deny}, {6'd0, exp_g, exp_d});
  endtask

  task automatic done_pulse();
    @(negedge clk); wr_done = 1'b1;
    @(negedge clk); wr_done = 1'b0;
  endtask

  task automatic set_reg(input logic [7:0] v);
    cmd(2'd0, '0, 8'h00, "R2", 1'b0, 1'b0);
    cmd(2'd3, '0, v, "R6", 1'b1, 1'b0);
    done_pulse();
  endtask

  task automatic t_reset();
    chk("R1 reset", status_q, 8'h00);
  endtask

  task automatic t_wel();
    cmd(2'd0, '0, 8'h00, "R2", 1'b0, 1'b0);
    chk("R2 set", status_q, 8'h02);
    cmd(2'd1, '0, 8'h00, "R2", 1'b0, 1'b0);
    chk("R2 clear", status_q, 8'h00);
  endtask

  task automatic t_mem_write();
    cmd(2'd2, 12'h123, 8'h00, "R3 no enable", 1'b0, 1'b1);
    chk("R3 state", status_q, 8'h00);
    cmd(2'd0, '0, 8'h00, "R2", 1'b0, 1'b0);
    cmd(2'd2, 12'h123, 8'h00, "R3 granted", 1'b1, 1'b0);
    chk("R5 wip", status_q, 8'h03);
    cmd(2'd2, 12'h124, 8'h00, "R9 busy", 1'b0, 1'b1);
    cmd(2'd0, '0, 8'h00, "R9", 1'b0, 1'b0);
    cmd(2'd3, '0, 8'h80, "R9 busy reg", 1'b0, 1'b1);
    done_pulse();
    chk("R5 complete", status_q, 8'h00);
  endtask

  task automatic t_reg_write();
    cmd(2'd0, '0, 8'h00, "R2", 1'b0, 1'b0);
    cmd(2'd3, '0, 8'hFF, "R6 granted", 1'b1, 1'b0);
    chk("R6 old bits held", status_q, 8'h03);
    repeat (3) @(negedge clk);
    chk("R6 still old", status_q, 8'h03);
    done_pulse();
    chk("R6 committed", status_q, 8'h8C);
  endtask

  task automatic t_hw_lock();
    wp_n = 1'b0;
    cmd(2'd0, '0, 8'h00, "R2", 1'b0, 1'b0);
    cmd(2'd3, '0, 8'h00, "R7 locked", 1'b0, 1'b1);
    chk("R7 unchanged", status_q, 8'h8E);
    wp_n = 1'b1;
    cmd(2'd3, '0, 8'h04, "R7 released", 1'b1, 1'b0);
    done_pulse();
    chk("R7 new value", status_q, 8'h04);
  endtask

  task automatic t_regions();
    cmd(2'd0, '0, 8'h00, "R2", 1'b0, 1'b0);
    cmd(2'd2, 12'hBFF, 8'h00, "R4 quarter below", 1'b1, 1'b0);
    done_pulse();
    cmd(2'd0, '0, 8'h00, "R2", 1'b0, 1'b0);
    cmd(2'd2, 12'hC00, 8'h00, "R4 quarter edge", 1'b0, 1'b1);
    chk("R4 enable kept", status_q, 8'h06);
    set_reg(8'h08);
    cmd(2'd0, '0, 8'h00, "R2", 1'b0, 1'b0);
    cmd(2'd2, 12'h800, 8'h00, "R4 half edge", 1'b0, 1'b1);
    cmd(2'd2, 12'h7FF, 8'h00, "R4 half below", 1'b1, 1'b0);
    done_pulse();
    set_reg(8'h0C);
    cmd(2'd0, '0, 8'h00, "R2", 1'b0, 1'b0);
    cmd(2'd2, 12'h000, 8'h00, "R4 full", 1'b0, 1'b1);
    cmd(2'd1, '0, 8'h00, "R2", 1'b0, 1'b0);
    set_reg(8'h00);
    cmd(2'd0, '0, 8'h00, "R2", 1'b0, 1'b0);
    cmd(2'd2, 12'hFFF, 8'h00, "R4 none", 1'b1, 1'b0);
    done_pulse();
    chk("R4 final", status_q, 8'h00);
  endtask

  task automatic t_lvd();
    cmd(2'd0, '0, 8'h00, "R2", 1'b0, 1'b0);
    cmd(2'd3, '0, 8'h8C, "R8 setup", 1'b1, 1'b0);
    @(negedge clk); lvd = 1'b1;
    @(negedge clk); lvd = 1'b0;
    chk("R8 cleared", status_q, 8'h00);
    done_pulse();
    chk("R8 value dropped", status_q, 8'h00);
    cmd(2'd0, '0, 8'h00, "R2", 1'b0, 1'b0);
    @(negedge clk);
    lvd = 1'b1; cmd_valid = 1'b1; cmd_op = 2'd2; cmd_addr = 12'h010;
    @(negedge clk);
    lvd = 1'b0; cmd_valid = 1'b0;
    chk("R8 concurrent deny", {6'd0, grant, deny}, 8'h01);
    chk("R8 latch cleared", status_q, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wel();
    t_mem_write();
    t_reg_write();
    t_hw_lock();
    t_regions();
    t_lvd();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule